// File: doc/BRIEF.md
# Core-Valid Snoop Target Tracker

This block keeps coherence metadata for the lines of one shared last-level cache slice. A direct-indexed directory holds, for every index, an address tag, a five-state MESIF field and a presence vector with one bit per local core. The bit for a core is set when that core may hold the line in its private cache.

All work arrives on a single request port, one operation per cycle. A local coherent read asks whether another local core owns the line and must be snooped. An external snoop, either shared or invalidating, asks which local cores must see it. Core fills and core evictions update the presence vector.

Every request gets a registered response one cycle later. The response carries the snoop-target vector, a hit flag and the state the line had when the request looked it up. Data movement, the interconnect and the address hashing are handled elsewhere.

Top module: `cv_snoop_dir`

## Requirements
- R1: After reset every line is Invalid with an empty presence vector, and `rsp_valid` is low.
- R2: A request accepted on a clock edge has its response on the next edge. `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high.
- R3: States are coded I=0, S=1, E=2, M=3 and F=4. Operations are coded local read=0, shared snoop=1, invalidating snoop=2, fill=3 and evict=4. `rsp_state` reports the state the line had before the request, and it reports I on a tag mismatch.
- R4: A fill (op 3) stores the tag and the state given on `req_fill_state`, sets the filling core's bit and reports no targets. A fill whose tag differs from the stored tag replaces the line, leaving only the filler's bit.
- R5: An evict (op 4) that hits clears the requesting core's bit and reports no targets. When the last bit clears, the line becomes Invalid. An evict from a core whose bit is clear changes nothing.
- R6: A local read (op 0) reports as targets the presence bits other than the requester's own, but only when the line is E or M. For S, F or a miss it reports no targets.
- R7: A shared snoop (op 1) reports every presence bit as a target. It moves a line in M, E or F to S and keeps the presence bits.
- R8: An invalidating snoop (op 2) reports every presence bit as a target. It then leaves the line Invalid with an empty vector.
- R9: A lookup of an Invalid line, or one with a tag mismatch, reports `rsp_hit` low and zero targets.
- R10: These change no line: a fill whose state code is I or above 4, operation codes 5 to 7, and any cycle with `req_valid` low.
- R11: A request sees the update made by a request to the same line in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Operation code (R3) |
| req_addr | input | IDX_W+TAG_W | Line address: index in the low IDX_W bits, tag above |
| req_core | input | $clog2(N_CORES) | Requesting or filling/evicting core |
| req_fill_state | input | 3 | State written by a fill |
| rsp_valid | output | 1 | Response present |
| rsp_targets | output | N_CORES | Local cores to snoop |
| rsp_hit | output | 1 | Tag matched a non-Invalid line |
| rsp_state | output | 3 | Line state before the request |

## Verification
The bench goes after the requester's own bit on a local read. A design that forgot to mask that bit would send a core a snoop for its own read. It also checks that a read of a Shared or Forward line reports no targets, where a careless design would snoop every sharer. A replacing fill at an occupied index is checked to leave only the new filler's bit, and an evict of the last holder is checked to drop the line to Invalid. Stale bits in either case would show up as extra targets on a later lookup. Back-to-back requests to one line, ignored fill states and unused operation codes are run to catch a design that reads stale array contents or that writes when it should not.

// File: rtl/cv_dir_pkg.sv
package cv_dir_pkg;
    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_M = 3'd3,
        ST_F = 3'd4
    } mesif_e;

    typedef enum logic [2:0] {
        OP_RD      = 3'd0,
        OP_SNP_SH  = 3'd1,
        OP_SNP_INV = 3'd2,
        OP_FILL    = 3'd3,
        OP_EVICT   = 3'd4
    } dir_op_e;
endpackage

// File: rtl/cv_dir_store.sv
module cv_dir_store #(
    parameter int IDX_W   = 6,
    parameter int TAG_W   = 10,
    parameter int N_CORES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [2:0]         rd_st,
    output logic [N_CORES-1:0] rd_cv,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [2:0]         wr_st,
    input  logic [N_CORES-1:0] wr_cv
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0]   tag;
        logic [DEPTH-1:0][2:0]         st;
        logic [DEPTH-1:0][N_CORES-1:0] cv;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.tag[wr_idx] = wr_tag;
            s_d.st[wr_idx]  = wr_st;
            s_d.cv[wr_idx]  = wr_cv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_tag = s_q.tag[rd_idx];
    assign rd_st  = s_q.st[rd_idx];
    assign rd_cv  = s_q.cv[rd_idx];
endmodule

// File: rtl/cv_dir_lookup.sv
module cv_dir_lookup
    import cv_dir_pkg::*;
#(
    parameter int TAG_W   = 10,
    parameter int N_CORES = 8,
    parameter int CORE_W  = 3
) (
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic [CORE_W-1:0]  req_core,
    input  logic [2:0]         req_fill_state,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [TAG_W-1:0]   ent_tag,
    input  logic [2:0]         ent_st,
    input  logic [N_CORES-1:0] ent_cv,
    output logic               hit,
    output logic [2:0]         cur_st,
    output logic [N_CORES-1:0] targets,
    output logic               wr_en,
    output logic [TAG_W-1:0]   wr_tag,
    output logic [2:0]         wr_st,
    output logic [N_CORES-1:0] wr_cv
);
    logic [N_CORES-1:0] core_bit;
    logic [N_CORES-1:0] cur_cv;
    logic [N_CORES-1:0] left_cv;
    logic               owned;
    logic               fill_ok;

    always_comb begin
        core_bit           = '0;
        core_bit[req_core] = 1'b1;
        hit     = (ent_st != ST_I) && (ent_tag == req_tag);
        cur_st  = hit ? ent_st : ST_I;
        cur_cv  = hit ? ent_cv : '0;
        left_cv = cur_cv & ~core_bit;
        owned   = (cur_st == ST_E) || (cur_st == ST_M);
        fill_ok = (req_fill_state != ST_I) && (req_fill_state <= ST_F);

        targets = '0;
        wr_en   = 1'b0;
        wr_tag  = ent_tag;
        wr_st   = ent_st;
        wr_cv   = ent_cv;

        case (req_op)
            OP_RD: begin
                targets = owned ? left_cv : '0;
            end
            OP_SNP_SH: begin
                targets = cur_cv;
                if (hit && cur_st != ST_S) begin
                    wr_en = req_valid;
                    wr_st = ST_S;
                end
            end
            OP_SNP_INV: begin
                targets = cur_cv;
                if (hit) begin
                    wr_en = req_valid;
                    wr_st = ST_I;
                    wr_cv = '0;
                end
            end
            OP_FILL: begin
                if (fill_ok) begin
                    wr_en  = req_valid;
                    wr_tag = req_tag;
                    wr_st  = req_fill_state;
                    wr_cv  = cur_cv | core_bit;
                end
            end
            OP_EVICT: begin
                if (hit && (cur_cv & core_bit) != '0) begin
                    wr_en = req_valid;
                    wr_cv = left_cv;
                    wr_st = (left_cv == '0) ? ST_I : cur_st;
                end
            end
            default: begin
                targets = '0;
            end
        endcase
    end
endmodule

// File: rtl/cv_snoop_dir.sv
module cv_snoop_dir
    import cv_dir_pkg::*;
#(
    parameter  int N_CORES = 8,
    parameter  int IDX_W   = 6,
    parameter  int TAG_W   = 10,
    localparam int CORE_W  = $clog2(N_CORES),
    localparam int ADDR_W  = IDX_W + TAG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [CORE_W-1:0]  req_core,
    input  logic [2:0]         req_fill_state,
    output logic               rsp_valid,
    output logic [N_CORES-1:0] rsp_targets,
    output logic               rsp_hit,
    output logic [2:0]         rsp_state
);
    typedef struct packed {
        logic               valid;
        logic [N_CORES-1:0] targets;
        logic               hit;
        logic [2:0]         state;
    } rsp_t;

    logic [IDX_W-1:0]   idx;
    logic [TAG_W-1:0]   tag;
    logic [TAG_W-1:0]   ent_tag;
    logic [2:0]         ent_st;
    logic [N_CORES-1:0] ent_cv;
    logic               lk_hit;
    logic [2:0]         lk_st;
    logic [N_CORES-1:0] lk_targets;
    logic               wr_en;
    logic [TAG_W-1:0]   wr_tag;
    logic [2:0]         wr_st;
    logic [N_CORES-1:0] wr_cv;
    rsp_t               rsp_d, rsp_q;

    assign idx = req_addr[IDX_W-1:0];
    assign tag = req_addr[ADDR_W-1:IDX_W];

    cv_dir_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .N_CORES(N_CORES)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (idx),
        .rd_tag (ent_tag),
        .rd_st  (ent_st),
        .rd_cv  (ent_cv),
        .wr_en  (wr_en),
        .wr_idx (idx),
        .wr_tag (wr_tag),
        .wr_st  (wr_st),
        .wr_cv  (wr_cv)
    );

    cv_dir_lookup #(.TAG_W(TAG_W), .N_CORES(N_CORES), .CORE_W(CORE_W)) u_lookup (
        .req_valid      (req_valid),
        .req_op         (req_op),
        .req_core       (req_core),
        .req_fill_state (req_fill_state),
        .req_tag        (tag),
        .ent_tag        (ent_tag),
        .ent_st         (ent_st),
        .ent_cv         (ent_cv),
        .hit            (lk_hit),
        .cur_st         (lk_st),
        .targets        (lk_targets),
        .wr_en          (wr_en),
        .wr_tag         (wr_tag),
        .wr_st          (wr_st),
        .wr_cv          (wr_cv)
    );

    always_comb begin
        rsp_d = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.targets = lk_targets;
            rsp_d.hit     = lk_hit;
            rsp_d.state   = lk_st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_targets = rsp_q.targets;
    assign rsp_hit     = rsp_q.hit;
    assign rsp_state   = rsp_q.state;
endmodule

// File: rtl/cv_snoop_dir_chk.sv
module cv_snoop_dir_chk
    import cv_dir_pkg::*;
#(
    parameter int N_CORES = 8,
    parameter int CORE_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [2:0]         req_op,
    input logic [CORE_W-1:0]  req_core,
    input logic               rsp_valid,
    input logic [N_CORES-1:0] rsp_targets,
    input logic               rsp_hit,
    input logic [2:0]         rsp_state
);
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_state_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_state <= 3'd4);

    p_inv_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_state == 3'd0) |-> (rsp_targets == '0 && !rsp_hit));

    p_fill_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_FILL) |=> rsp_targets == '0);

    p_evict_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_EVICT) |=> rsp_targets == '0);

    p_rd_not_self_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_RD) |=> rsp_targets[$past(req_core)] == 1'b0);

    p_rd_owned_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_RD) |=>
            (rsp_state == 3'd2 || rsp_state == 3'd3 || rsp_targets == '0));
endmodule

bind cv_snoop_dir cv_snoop_dir_chk #(.N_CORES(N_CORES), .CORE_W(CORE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_core    (req_core),
    .rsp_valid   (rsp_valid),
    .rsp_targets (rsp_targets),
    .rsp_hit     (rsp_hit),
    .rsp_state   (rsp_state)
);

// File: tb/cv_snoop_dir_bench.sv
module cv_snoop_dir_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [15:0] req_addr = '0;
    logic [2:0] req_core = '0;
    logic [2:0] req_fill_state = '0;
    logic       rsp_valid;
    logic [7:0] rsp_targets;
    logic       rsp_hit;
    logic [2:0] rsp_state;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cv_snoop_dir u_cv_snoop_dir (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_core(req_core), .req_fill_state(req_fill_state),
        .rsp_valid(rsp_valid), .rsp_targets(rsp_targets), .rsp_hit(rsp_hit),
        .rsp_state(rsp_state)
    );

    // op, addr, core, fill state, expected targets, state, hit, requirement
    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] addr;
        logic [2:0]  core;
        logic [2:0]  fst;
        logic [7:0]  tgt;
        logic [2:0]  st;
        logic        hit;
        logic [7:0]  rq;
    } vec_t;

    // A = tag 0x12 idx 5, B = tag 0x34 idx 5, C = tag 0x12 idx 63
    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 16'h0485, 3'd0, 3'd0, 8'h00, 3'd0, 1'b0, 8'd9},  // R9 empty line
        '{3'd3, 16'h0485, 3'd2, 3'd2, 8'h00, 3'd0, 1'b0, 8'd4},  // R4 fill E
        '{3'd0, 16'h0485, 3'd5, 3'd0, 8'h04, 3'd2, 1'b1, 8'd6},  // R6 owner snooped
        '{3'd0, 16'h0485, 3'd2, 3'd0, 8'h00, 3'd2, 1'b1, 8'd6},  // R6 own bit masked
        '{3'd3, 16'h0485, 3'd5, 3'd1, 8'h00, 3'd2, 1'b1, 8'd4},  // R4 second sharer
        '{3'd0, 16'h0485, 3'd0, 3'd0, 8'h00, 3'd1, 1'b1, 8'd6},  // R6 S no snoop
        '{3'd1, 16'h0485, 3'd0, 3'd0, 8'h24, 3'd1, 1'b1, 8'd7},  // R7 all sharers
        '{3'd3, 16'h0485, 3'd7, 3'd3, 8'h00, 3'd1, 1'b1, 8'd4},  // R4 fill M
        '{3'd0, 16'h0485, 3'd7, 3'd0, 8'h24, 3'd3, 1'b1, 8'd6},  // R6 M minus self
        '{3'd1, 16'h0485, 3'd0, 3'd0, 8'hA4, 3'd3, 1'b1, 8'd7},  // R7 M -> S
        '{3'd0, 16'h0485, 3'd0, 3'd0, 8'h00, 3'd1, 1'b1, 8'd7},  // R7 now S
        '{3'd4, 16'h0485, 3'd5, 3'd0, 8'h00, 3'd1, 1'b1, 8'd5},  // R5 evict one
        '{3'd2, 16'h0485, 3'd0, 3'd0, 8'h84, 3'd1, 1'b1, 8'd8},  // R8 inval targets
        '{3'd0, 16'h0485, 3'd1, 3'd0, 8'h00, 3'd0, 1'b0, 8'd8},  // R8 now I
        '{3'd3, 16'h0485, 3'd3, 3'd4, 8'h00, 3'd0, 1'b0, 8'd4},  // R4 fill F
        '{3'd1, 16'h0485, 3'd0, 3'd0, 8'h08, 3'd4, 1'b1, 8'd3},  // R3 F code 4
        '{3'd0, 16'h0D05, 3'd0, 3'd0, 8'h00, 3'd0, 1'b0, 8'd9},  // R9 tag miss
        '{3'd3, 16'h0D05, 3'd1, 3'd3, 8'h00, 3'd0, 1'b0, 8'd4},  // R4 replace
        '{3'd0, 16'h0485, 3'd0, 3'd0, 8'h00, 3'd0, 1'b0, 8'd4},  // R4 old tag gone
        '{3'd0, 16'h0D05, 3'd0, 3'd0, 8'h02, 3'd3, 1'b1, 8'd4},  // R4 only filler bit
        '{3'd4, 16'h0D05, 3'd1, 3'd0, 8'h00, 3'd3, 1'b1, 8'd5},  // R5 last holder
        '{3'd0, 16'h0D05, 3'd0, 3'd0, 8'h00, 3'd0, 1'b0, 8'd5},  // R5 now I
        '{3'd3, 16'h04BF, 3'd0, 3'd0, 8'h00, 3'd0, 1'b0, 8'd10}, // R10 fill state I
        '{3'd0, 16'h04BF, 3'd1, 3'd0, 8'h00, 3'd0, 1'b0, 8'd10}, // R10 still I
        '{3'd3, 16'h04BF, 3'd4, 3'd2, 8'h00, 3'd0, 1'b0, 8'd11}, // R11 fill E
        '{3'd7, 16'h04BF, 3'd2, 3'd3, 8'h00, 3'd2, 1'b1, 8'd11}, // R11 sees fill
        '{3'd0, 16'h04BF, 3'd0, 3'd0, 8'h10, 3'd2, 1'b1, 8'd10}, // R10 op 7 no-op
        '{3'd4, 16'h04BF, 3'd0, 3'd0, 8'h00, 3'd2, 1'b1, 8'd5},  // R5 evict non-holder
        '{3'd0, 16'h04BF, 3'd1, 3'd0, 8'h10, 3'd2, 1'b1, 8'd5}   // R5 unchanged
    };

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got valid/tgt/st/hit=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [15:0] a,
                         input logic [2:0] c, input logic [2:0] f);
        req_valid = 1'b1; req_op = op; req_addr = a; req_core = c; req_fill_state = f;
    endtask

    function automatic logic [12:0] pack(input logic v, input logic [7:0] t,
                                         input logic [2:0] s, input logic h);
        return {v, t, s, h};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rsp", pack(rsp_valid, rsp_targets, rsp_state, rsp_hit), 13'h0);
        rst_n = 1'b1;
        // R10: a fill with req_valid low must not write
        req_valid = 1'b0; req_op = 3'd3; req_addr = 16'h0485; req_core = 3'd6; req_fill_state = 3'd3;
        @(negedge clk);
        check("R2 idle no rsp", pack(rsp_valid, rsp_targets, rsp_state, rsp_hit), 13'h0);
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].addr, VECS[i].core, VECS[i].fst);
            @(negedge clk);
            check($sformatf("R%0d vec %0d", VECS[i].rq, i),
                  pack(rsp_valid, rsp_targets, rsp_state, rsp_hit),
                  pack(1'b1, VECS[i].tgt, VECS[i].st, VECS[i].hit));
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 valid drops", pack(rsp_valid, rsp_targets, rsp_state, rsp_hit), 13'h0);
        // R1: reset mid-run clears the line C
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 async reset", pack(rsp_valid, rsp_targets, rsp_state, rsp_hit), 13'h0);
        rst_n = 1'b1;
        drive(3'd0, 16'h04BF, 3'd1, 3'd0);
        @(negedge clk);
        check("R1 lines invalid", pack(rsp_valid, rsp_targets, rsp_state, rsp_hit),
              pack(1'b1, 8'h00, 3'd0, 1'b0));
        req_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule